// File: doc/BRIEF.md
# Thread-Aware Branch Target Buffer

This block is a direct-mapped table that remembers where taken branches went. A fetch stage presents an instruction address and the number of the hardware thread it is fetching for. In the same cycle the block answers whether it holds a target for that pair and, if so, what the target is. A resolve stage writes back observed (address, thread, target) triples through a separate update port. A synchronous clear input drops every entry at once, for example on a context flush.

The set index mixes the thread number into its upper bits, so the same code running on different threads lands in different slots. Each slot also stores the thread that wrote it, and a lookup only hits when address tag and thread both match. The entry count, tag width, instruction-alignment shift, thread count and address width are parameters. Elaboration stops with an error unless the entry count is a power of two of at least 2, the thread count is a power of two no larger than the entry count, and the tag fits in the address.

Top module: `thread_btb`

## Requirements
- R1: After a synchronous reset every lookup misses, for every address and thread.
- R2: The slot index is ((pc >> ALIGN_SHIFT) XOR (tid << (log2(ENTRIES) - log2(THREADS)))) truncated to log2(ENTRIES) bits. An update to one slot evicts whatever that slot held before.
- R3: The tag is (pc >> (ALIGN_SHIFT + log2(ENTRIES))) truncated to TAG_W bits. Address bits above that field do not affect a hit. A differing tag at the same slot misses.
- R4: A lookup hits only if the slot is valid, its stored tag equals the computed tag and its stored thread equals `lk_tid`. A matching tag with a different thread misses.
- R5: On a miss `lk_target` is all zeros.
- R6: An update overwrites its slot without checking whether it is occupied. It stores tag, thread and target, and sets valid. The new contents are seen by lookups from the next cycle on.
- R7: A lookup in the same cycle as an update to the same slot returns the slot's old contents.
- R8: A cycle with `clr` high invalidates every slot. If an update arrives in that cycle, the clear wins and the update leaves nothing valid.
- R9: When THREADS > 1, the same address written by different threads occupies distinct slots, and each thread hits its own target.
- R10: The low ALIGN_SHIFT address bits are ignored by both index and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; invalidates all slots |
| clr | input | 1 | Synchronous flush of all slots; wins over a concurrent update |
| lk_pc | input | PC_W | Lookup instruction address |
| lk_tid | input | TID_W | Lookup thread number |
| lk_hit | output | 1 | Lookup found a matching valid slot |
| lk_target | output | PC_W | Predicted target on a hit, zero on a miss |
| up_en | input | 1 | Write the update triple this cycle |
| up_pc | input | PC_W | Update instruction address |
| up_tid | input | TID_W | Update thread number |
| up_target | input | PC_W | Target to store |

## Verification
The bench runs a 16-slot, 4-thread, 4-bit-tag configuration. First it sweeps every slot against four tags, four threads and varying low alignment bits on an empty table; this separates a correct reset from stale state. It then fills the same few addresses from all four threads. Sweeping the full address and thread space after that fill tells a missing thread-XOR apart from a missing thread compare, because each fault produces wrong hits at different addresses. Directed cases put tag-only and thread-only mismatches on one slot, eviction through the XOR alias, old-versus-new data on a same-cycle update, and a clear that collides with an update. A long pseudo-random mix of updates, lookups and rare clears is compared against an arithmetic model of the table.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // True when v is a nonzero power of two.
  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/btb_hash.sv
// Turns an address and thread number into a slot index and a tag.
module btb_hash #(
  parameter int PC_W        = 32,
  parameter int IDX_W       = 6,
  parameter int LOG2T       = 2,
  parameter int TID_W       = 2,
  parameter int TAG_W       = 8,
  parameter int ALIGN_SHIFT = 2
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [TID_W-1:0] tid,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  logic [IDX_W-1:0] thread_mix;

  generate
    if (LOG2T > 0) begin : g_mix
      // thread number lands in the top LOG2T index bits
      assign thread_mix = IDX_W'(tid) << (IDX_W - LOG2T);
    end else begin : g_nomix
      assign thread_mix = '0;
    end
  endgenerate

  assign idx = IDX_W'(pc >> ALIGN_SHIFT) ^ thread_mix;
  assign tag = TAG_W'(pc >> (ALIGN_SHIFT + IDX_W));

endmodule

// File: rtl/btb_valid_bits.sv
// One valid flag per slot, held in flops so that a flush clears all in one cycle.
module btb_valid_bits #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);

  logic [ENTRIES-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags <= '0;
    end else if (set_en) begin
      flags[set_idx] <= 1'b1;
    end
  end

  assign rd_valid = flags[rd_idx];

endmodule

// File: rtl/btb_payload_ram.sv
// Single-write, asynchronous-read storage for tag, thread and target.
// No reset: contents only matter behind a set valid flag.
module btb_payload_ram #(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 42,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/thread_btb.sv
module thread_btb #(
  parameter int ENTRIES     = 64,
  parameter int TAG_W       = 8,
  parameter int ALIGN_SHIFT = 2,
  parameter int THREADS     = 4,
  parameter int PC_W        = 32,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int LOG2T      = $clog2(THREADS),
  localparam int TID_W      = (LOG2T > 0) ? LOG2T : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [TID_W-1:0] lk_tid,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_target,
  input  logic             up_en,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [TID_W-1:0] up_tid,
  input  logic [PC_W-1:0]  up_target
);

  localparam int PAY_W = TID_W + TAG_W + PC_W;

  // Configuration guards
  generate
    if (!btb_pkg::is_pow2(ENTRIES) || ENTRIES < 2) begin : g_bad_entries
      $error("thread_btb: ENTRIES must be a power of two and at least 2");
    end
    if (!btb_pkg::is_pow2(THREADS) || THREADS > ENTRIES) begin : g_bad_threads
      $error("thread_btb: THREADS must be a power of two not above ENTRIES");
    end
    if (TAG_W < 1 || TAG_W > PC_W) begin : g_bad_tag
      $error("thread_btb: TAG_W must lie between 1 and PC_W");
    end
  endgenerate

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  btb_hash #(
    .PC_W(PC_W), .IDX_W(IDX_W), .LOG2T(LOG2T), .TID_W(TID_W),
    .TAG_W(TAG_W), .ALIGN_SHIFT(ALIGN_SHIFT)
  ) u_hash_rd (
    .pc(lk_pc), .tid(lk_tid), .idx(rd_idx), .tag(rd_tag)
  );

  btb_hash #(
    .PC_W(PC_W), .IDX_W(IDX_W), .LOG2T(LOG2T), .TID_W(TID_W),
    .TAG_W(TAG_W), .ALIGN_SHIFT(ALIGN_SHIFT)
  ) u_hash_wr (
    .pc(up_pc), .tid(up_tid), .idx(wr_idx), .tag(wr_tag)
  );

  logic slot_valid;

  btb_valid_bits #(.ENTRIES(ENTRIES)) u_valid (
    .clk(clk), .rst(rst), .clr(clr),
    .set_en(up_en), .set_idx(wr_idx),
    .rd_idx(rd_idx), .rd_valid(slot_valid)
  );

  logic [PAY_W-1:0] pay_wr, pay_rd;
  logic [TID_W-1:0] stored_tid;
  logic [TAG_W-1:0] stored_tag;
  logic [PC_W-1:0]  stored_target;

  assign pay_wr = {up_tid, wr_tag, up_target};

  btb_payload_ram #(.ENTRIES(ENTRIES), .WIDTH(PAY_W)) u_payload (
    .clk(clk), .wr_en(up_en), .wr_idx(wr_idx), .wr_data(pay_wr),
    .rd_idx(rd_idx), .rd_data(pay_rd)
  );

  assign {stored_tid, stored_tag, stored_target} = pay_rd;

  always_comb begin
    lk_hit    = slot_valid && (stored_tag == rd_tag) && (stored_tid == lk_tid);
    lk_target = lk_hit ? stored_target : '0;
  end

endmodule

// File: rtl/thread_btb_chk.sv
module thread_btb_chk #(
  parameter int PC_W  = 32,
  parameter int TID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic [PC_W-1:0]  lk_pc,
  input logic [TID_W-1:0] lk_tid,
  input logic             lk_hit,
  input logic [PC_W-1:0]  lk_target,
  input logic             up_en,
  input logic [PC_W-1:0]  up_pc,
  input logic [TID_W-1:0] up_tid,
  input logic [PC_W-1:0]  up_target
);

  // First cycle out of reset: nothing can hit.
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  // A flush leaves no slot able to hit on the following cycle.
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !lk_hit);

  // A written pair, looked up next cycle, returns what was written.
  assert_write_visible_R6: assert property (@(posedge clk) disable iff (rst)
    (up_en && !clr) |=> (!(lk_pc == $past(up_pc) && lk_tid == $past(up_tid))
                         || (lk_hit && lk_target == $past(up_target))));

  // Without writes or flushes the answer to an unchanged question is unchanged.
  assert_table_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!up_en && !clr) |=> (!($stable(lk_pc) && $stable(lk_tid))
                          || ($stable(lk_hit) && $stable(lk_target))));

endmodule

bind thread_btb thread_btb_chk #(.PC_W(PC_W), .TID_W(TID_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr),
  .lk_pc(lk_pc), .lk_tid(lk_tid), .lk_hit(lk_hit), .lk_target(lk_target),
  .up_en(up_en), .up_pc(up_pc), .up_tid(up_tid), .up_target(up_target)
);

// File: tb/thread_btb_tb.sv
`timescale 1ns/1ps
module thread_btb_tb;

  localparam int PW = 16;
  localparam int NE = 16;
  localparam int TW = 4;
  localparam int AS = 2;
  localparam int NT = 4;
  localparam int IW = 4;
  localparam int LT = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, clr = 1'b0, up_en = 1'b0;
  logic [PW-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
  logic [LT-1:0] lk_tid = '0, up_tid = '0;
  logic          lk_hit;
  logic [PW-1:0] lk_target;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Arithmetic model of the table
  bit            mv   [NE];
  logic [TW-1:0] mtag [NE];
  logic [LT-1:0] mtid [NE];
  logic [PW-1:0] mtgt [NE];

  thread_btb #(
    .ENTRIES(NE), .TAG_W(TW), .ALIGN_SHIFT(AS), .THREADS(NT), .PC_W(PW)
  ) u_dut (
    .clk(clk), .rst(rst), .clr(clr),
    .lk_pc(lk_pc), .lk_tid(lk_tid), .lk_hit(lk_hit), .lk_target(lk_target),
    .up_en(up_en), .up_pc(up_pc), .up_tid(up_tid), .up_target(up_target)
  );

  function automatic int idx_of(input logic [PW-1:0] pc, input logic [LT-1:0] t);
    return (int'(pc >> AS) ^ (int'(t) << (IW - LT))) & (NE - 1);
  endfunction

  function automatic int tag_of(input logic [PW-1:0] pc);
    return int'(pc >> (AS + IW)) & ((1 << TW) - 1);
  endfunction

  // One cycle: drive at negedge, compare just before posedge, then advance model.
  task automatic step(input bit we, input logic [PW-1:0] wpc, input logic [LT-1:0] wt,
                      input logic [PW-1:0] wtg, input bit cl,
                      input logic [PW-1:0] lpc, input logic [LT-1:0] lt,
                      input string req);
    int i;
    bit eh;
    logic [PW-1:0] et;
    @(negedge clk);
    up_en = we; up_pc = wpc; up_tid = wt; up_target = wtg;
    clr = cl; lk_pc = lpc; lk_tid = lt;
    #1;
    i  = idx_of(lpc, lt);
    eh = mv[i] && (int'(mtag[i]) == tag_of(lpc)) && (mtid[i] == lt);
    et = eh ? mtgt[i] : '0;
    checks++;
    if (lk_hit !== eh || lk_target !== et) begin
      errors++;
      $display("FAIL %s: pc=%h tid=%0d got hit=%0b target=%h, expected hit=%0b target=%h",
               req, lpc, lt, lk_hit, lk_target, eh, et);
    end
    if (cl) begin
      for (int k = 0; k < NE; k++) mv[k] = 1'b0;
    end else if (we) begin
      i = idx_of(wpc, wt);
      mv[i] = 1'b1; mtag[i] = TW'(tag_of(wpc)); mtid[i] = wt; mtgt[i] = wtg;
    end
  endtask

  task automatic look(input logic [PW-1:0] pc, input logic [LT-1:0] t, input string req);
    step(1'b0, '0, '0, '0, 1'b0, pc, t, req);
  endtask

  task automatic wr(input logic [PW-1:0] pc, input logic [LT-1:0] t,
                    input logic [PW-1:0] tg, input string req);
    step(1'b1, pc, t, tg, 1'b0, pc, t, req);
  endtask

  // All slots x four tags x all threads, low alignment bits varied.
  task automatic sweep(input string req);
    for (int t = 0; t < NT; t++)
      for (int g = 0; g < 4; g++)
        for (int s = 0; s < NE; s++)
          look(PW'((g << (AS + IW)) | (s << AS) | ((s + t) & 3)), LT'(t), req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion before timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    automatic int unsigned lf = 32'h1234_5678;
    for (int k = 0; k < NE; k++) mv[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R5: empty table
    sweep("R1");
    look(16'h0124, 2'd3, "R5");

    // R9: same addresses from every thread, distinct slots
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < 4; s++)
        wr(PW'(s << AS), LT'(t), PW'(16'hA000 | (t << 4) | s), "R9");
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < 4; s++)
        look(PW'(s << AS), LT'(t), "R9");
    sweep("R4");

    // R4: same slot and tag, different thread
    look(16'h0014, 2'd1, "R4");
    // R3: same slot, other tag; bits above tag field ignored
    look(16'h0044, 2'd0, "R3");
    look(16'h0404, 2'd0, "R3");
    // R10: alignment bits ignored
    look(16'h0007, 2'd0, "R10");

    // R2: thread-XOR alias evicts slot 1
    wr(16'h0094, 2'd1, 16'hBEEF, "R2");
    look(16'h0004, 2'd0, "R2");
    look(16'h0094, 2'd1, "R6");

    // R7: same-cycle update returns old contents, new one next cycle
    step(1'b1, 16'h0094, 2'd1, 16'hC0DE, 1'b0, 16'h0094, 2'd1, "R7");
    look(16'h0094, 2'd1, "R6");

    // R8: clear colliding with an update
    step(1'b1, 16'h0008, 2'd2, 16'h5555, 1'b1, 16'h0008, 2'd2, "R8");
    look(16'h0008, 2'd2, "R8");
    sweep("R8");

    // R6: pseudo-random mix
    for (int n = 0; n < 3000; n++) begin
      logic [PW-1:0] a, b;
      bit we, cl;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      a  = PW'(lf[9:0]);
      b  = PW'(lf[25:16]);
      we = lf[26];
      cl = (lf[31:27] == 5'd0);
      step(we, a, LT'(lf[11:10]), PW'(lf[31:16] ^ lf[15:0]), cl,
           lf[30] ? a : b, LT'(lf[29:28]), "R6");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule